// File: doc/BRIEF.md
# Shared Hash-Table Lookup Resolver

This block settles address lookups that an on-chip membership filter could not decide. Several filter engines post requests into one shared queue. Each request carries the engine's own tag, two precomputed table indexes, the search key and the prefix length under test. The resolver takes one request at a time from the head of the queue and probes a single hash table in a fixed order. It then returns either a hit with the stored output port or a miss to the engine that made the request. On a miss the engine goes on to a shorter length.

Each table entry holds a key prefix, its length, an output port and an overflow pointer. A stored key can sit in three places: the slot named by the first index, the slot named by the second index, or the slot named by the overflow pointer kept in that second slot. The table is modelled as a synchronous RAM whose read latency is a parameter. A plain write port loads the table, because building the table is not this block's job.

Top module: `hash_resolver`

## Requirements
- R1: After reset no response is presented (`rsp_valid` low) and every engine sees `req_ready` high.
- R2: When the entry at the first index matches, the response has `rsp_hit`=1 and carries that entry's port.
- R3: When the first entry does not match and the entry at the second index does, the response carries the second entry's port.
- R4: When neither indexed entry matches, the entry named by the overflow pointer of the second entry is probed, and a match there returns its port.
- R5: The probe order is fixed. If the first and the second entry both match, the first entry's port is returned.
- R6: When none of the probed entries match, the response has `rsp_hit`=0 and `rsp_port`=0.
- R7: An overflow pointer of all ones means no third entry. The third probe is skipped, even if the entry at that address would match.
- R8: An entry matches only if its stored length equals the request length and the key equals the stored prefix in the top `length` bits. Lower key bits are ignored. An entry whose length field is all ones is empty and never matches.
- R9: Requests are served and answered in arrival order. Each response returns the request's tag on `rsp_tag` and the number of the pushing engine on `rsp_eng`.
- R10: When several engines push in the same cycle, the lower-numbered engine is queued, and so answered, first.
- R11: `req_ready[e]` is high exactly when the queue has at least e+1 free slots. This makes the ready vector a low-aligned run of ones, and it is all zero when the queue is full.
- R12: Every accepted request produces exactly one response, and `rsp_valid` is high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NUM_ENG | Per-engine request strobe |
| req_ready | output | NUM_ENG | Per-engine acceptance; a request is taken when valid and ready are both high |
| req_tag | input | NUM_ENG*TAG_W | Per-engine tag, returned with the response |
| req_idx1 | input | NUM_ENG*IDX_W | Per-engine first table index |
| req_idx2 | input | NUM_ENG*IDX_W | Per-engine second table index |
| req_key | input | NUM_ENG*KEY_W | Per-engine search key |
| req_len | input | NUM_ENG*LEN_W | Per-engine prefix length under test |
| tbl_we | input | 1 | Table write strobe |
| tbl_waddr | input | IDX_W | Table write address |
| tbl_wprefix | input | KEY_W | Stored prefix |
| tbl_wlen | input | LEN_W | Stored length; all ones marks the entry empty |
| tbl_wport | input | PORT_W | Stored output port |
| tbl_wnext | input | IDX_W | Overflow pointer; all ones means none |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_eng | output | ENG_W | Engine that pushed the answered request |
| rsp_tag | output | TAG_W | Tag of the answered request |
| rsp_hit | output | 1 | 1 if a matching entry was found |
| rsp_port | output | PORT_W | Port of the matching entry, 0 on a miss |

## Verification
A wrong probe stage or a wrong choice of entry shows on the very next response as a wrong port or a wrong hit flag. That response arrives within about three read latencies of the request reaching the head of the queue. A corrupted queue pointer or fill count shows as a response carrying the wrong tag or engine, or arriving in the wrong order. It can also show as a ready pattern that no longer tracks the number of free slots, which the bench sees as soon as the queue fills. The sweep covers every pair of table indexes, with hits in every slot and misses, so a fault in the entry decoding or the masking surfaces within one sweep entry.

// File: rtl/rsl_pkg.sv
// Shared types for the hash-table resolver.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package rsl_pkg;

    // Controller phase: idle or waiting on a table read.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } rsl_state_e;

    // Which of the three candidate slots is being read.
    typedef enum logic [1:0] {
        PRB_FIRST  = 2'd0,
        PRB_SECOND = 2'd1,
        PRB_CHAIN  = 2'd2
    } rsl_stage_e;

endpackage

// File: rtl/rsl_table.sv
// Hash-table storage modelled as a synchronous RAM.
// One write port and one read port. Read data is valid RD_LAT cycles
// after rd_en is sampled, and rd_valid marks that cycle.
// Assumes RD_LAT >= 1. The array has no reset: the user loads it before use.
module rsl_table #(
    parameter int DEPTH  = 16,
    parameter int IDX_W  = 4,
    parameter int ENT_W  = 48,
    parameter int RD_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [ENT_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_addr,
    output logic             rd_valid,
    output logic [ENT_W-1:0] rd_data
);

    logic [ENT_W-1:0] mem [DEPTH];
    logic [ENT_W-1:0] pipe_d [RD_LAT];
    logic [RD_LAT-1:0] pipe_v;

    // Store written entries.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Read data pipeline modelling the access latency.
    always_ff @(posedge clk) begin
        pipe_d[0] <= mem[rd_addr];
        for (int i = 1; i < RD_LAT; i++) pipe_d[i] <= pipe_d[i-1];
    end

    // Valid shadow of the read pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_v <= '0;
        end else begin
            pipe_v[0] <= rd_en;
            for (int i = 1; i < RD_LAT; i++) pipe_v[i] <= pipe_v[i-1];
        end
    end

    assign rd_valid = pipe_v[RD_LAT-1];
    assign rd_data  = pipe_d[RD_LAT-1];

endmodule

// File: rtl/rsl_req_queue.sv
// Circular request queue shared by several engines, with several
// pushes per cycle and one pop.
// Engines that push in the same cycle are stored in ascending engine order.
// Engine e is ready while at least e+1 slots are free, so all the
// accepted pushes always fit.
// Assumes QDEPTH is a power of two and NUM_ENG <= QDEPTH.
module rsl_req_queue #(
    parameter int NUM_ENG = 2,
    parameter int QDEPTH  = 4,
    parameter int ELEM_W  = 8,
    parameter int CNT_W   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_ENG-1:0]        push_valid,
    input  logic [NUM_ENG*ELEM_W-1:0] push_data,
    output logic [NUM_ENG-1:0]        push_ready,
    input  logic                      pop,
    output logic [ELEM_W-1:0]         head_data,
    output logic                      empty,
    output logic [CNT_W-1:0]          count
);

    localparam int PTR_W = $clog2(QDEPTH);

    logic [ELEM_W-1:0] slots [QDEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  cnt_q, free_slots, n_push;
    logic [PTR_W-1:0]  slot_idx [NUM_ENG];
    logic [NUM_ENG-1:0] accept;

    assign free_slots = CNT_W'(QDEPTH) - cnt_q;

    for (genvar g = 0; g < NUM_ENG; g++) begin : g_ready
        assign push_ready[g] = free_slots > CNT_W'(g);
    end

    assign accept = push_valid & push_ready;

    // Give each accepting engine its slot, in ascending engine order.
    always_comb begin
        n_push = '0;
        for (int e = 0; e < NUM_ENG; e++) begin
            slot_idx[e] = wr_ptr + n_push[PTR_W-1:0];
            if (accept[e]) n_push = n_push + 1'b1;
        end
    end

    // Write the accepted elements.
    always_ff @(posedge clk) begin
        for (int e = 0; e < NUM_ENG; e++) begin
            if (accept[e]) slots[slot_idx[e]] <= push_data[e*ELEM_W +: ELEM_W];
        end
    end

    // Pointer and fill-count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            wr_ptr <= wr_ptr + n_push[PTR_W-1:0];
            rd_ptr <= rd_ptr + PTR_W'(pop);
            cnt_q  <= cnt_q + n_push - CNT_W'(pop);
        end
    end

    assign head_data = slots[rd_ptr];
    assign empty     = (cnt_q == '0);
    assign count     = cnt_q;

endmodule

// File: rtl/rsl_prober.sv
// Serves the head request: reads the first-index slot, then the
// second-index slot, then the slot named by the second slot's overflow
// pointer, and stops at the first match.
// A pointer of all ones skips the third read. An entry whose length is all
// ones is empty. The head is popped in the cycle the outcome is decided, and
// the response is registered at that same edge.
// Assumes the head stays stable until it is popped.
module rsl_prober
    import rsl_pkg::*;
#(
    parameter int KEY_W  = 32,
    parameter int LEN_W  = 6,
    parameter int PORT_W = 3,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 4,
    parameter int ENG_W  = 1,
    parameter int ENT_W  = KEY_W + LEN_W + PORT_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_valid,
    input  logic [ENG_W-1:0]  hd_eng,
    input  logic [TAG_W-1:0]  hd_tag,
    input  logic [IDX_W-1:0]  hd_idx1,
    input  logic [IDX_W-1:0]  hd_idx2,
    input  logic [KEY_W-1:0]  hd_key,
    input  logic [LEN_W-1:0]  hd_len,
    output logic              pop,
    output logic              rd_en,
    output logic [IDX_W-1:0]  rd_addr,
    input  logic              rd_valid,
    input  logic [ENT_W-1:0]  rd_data,
    output logic              rsp_valid,
    output logic [ENG_W-1:0]  rsp_eng,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic              rsp_hit,
    output logic [PORT_W-1:0] rsp_port
);

    rsl_state_e state_q, state_d;
    rsl_stage_e stage_q, stage_d;

    logic [KEY_W-1:0]  ent_prefix, len_mask;
    logic [LEN_W-1:0]  ent_len;
    logic [PORT_W-1:0] ent_port;
    logic [IDX_W-1:0]  ent_next;
    logic              ent_hit, finish;

    assign {ent_prefix, ent_len, ent_port, ent_next} = rd_data;

    // Match test: entry in use, same length, same prefix bits under the mask.
    assign len_mask = ~({KEY_W{1'b1}} >> ent_len);
    assign ent_hit  = (ent_len != '1) && (ent_len == hd_len) &&
                      (((ent_prefix ^ hd_key) & len_mask) == '0);

    // Next-state, read issue and completion decision.
    always_comb begin
        state_d = state_q;
        stage_d = stage_q;
        rd_en   = 1'b0;
        rd_addr = hd_idx1;
        finish  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (head_valid) begin
                    rd_en   = 1'b1;
                    state_d = ST_WAIT;
                    stage_d = PRB_FIRST;
                end
            end
            default: begin
                if (rd_valid) begin
                    if (ent_hit) begin
                        finish = 1'b1;
                    end else begin
                        case (stage_q)
                            PRB_FIRST: begin
                                rd_en   = 1'b1;
                                rd_addr = hd_idx2;
                                stage_d = PRB_SECOND;
                            end
                            PRB_SECOND: begin
                                if (ent_next == '1) begin
                                    finish = 1'b1;
                                end else begin
                                    rd_en   = 1'b1;
                                    rd_addr = ent_next;
                                    stage_d = PRB_CHAIN;
                                end
                            end
                            default: finish = 1'b1;
                        endcase
                    end
                    if (finish) state_d = ST_IDLE;
                end
            end
        endcase
    end

    assign pop = finish;

    // Controller state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            stage_q <= PRB_FIRST;
        end else begin
            state_q <= state_d;
            stage_q <= stage_d;
        end
    end

    // Registered response toward the engines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_eng   <= '0;
            rsp_tag   <= '0;
            rsp_hit   <= 1'b0;
            rsp_port  <= '0;
        end else begin
            rsp_valid <= finish;
            if (finish) begin
                rsp_eng  <= hd_eng;
                rsp_tag  <= hd_tag;
                rsp_hit  <= ent_hit;
                rsp_port <= ent_hit ? ent_port : '0;
            end
        end
    end

endmodule

// File: rtl/hash_resolver.sv
// Top of the shared hash-table resolver: per-engine request ports feed one
// tagged queue, a single prober serves its head against one table, and the
// answers go back on a shared response bus that names the engine and the tag.
// Assumes QDEPTH is a power of two, 2 <= NUM_ENG <= QDEPTH, and LEN_W wide
// enough to hold KEY_W, with all ones kept free as the empty code.
module hash_resolver #(
    parameter int NUM_ENG   = 2,
    parameter int TAG_W     = 4,
    parameter int KEY_W     = 32,
    parameter int LEN_W     = 6,
    parameter int PORT_W    = 3,
    parameter int TBL_DEPTH = 16,
    parameter int QDEPTH    = 4,
    parameter int RD_LAT    = 2,
    localparam int IDX_W    = $clog2(TBL_DEPTH),
    localparam int ENG_W    = $clog2(NUM_ENG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_ENG-1:0]       req_valid,
    output logic [NUM_ENG-1:0]       req_ready,
    input  logic [NUM_ENG*TAG_W-1:0] req_tag,
    input  logic [NUM_ENG*IDX_W-1:0] req_idx1,
    input  logic [NUM_ENG*IDX_W-1:0] req_idx2,
    input  logic [NUM_ENG*KEY_W-1:0] req_key,
    input  logic [NUM_ENG*LEN_W-1:0] req_len,
    input  logic                     tbl_we,
    input  logic [IDX_W-1:0]         tbl_waddr,
    input  logic [KEY_W-1:0]         tbl_wprefix,
    input  logic [LEN_W-1:0]         tbl_wlen,
    input  logic [PORT_W-1:0]        tbl_wport,
    input  logic [IDX_W-1:0]         tbl_wnext,
    output logic                     rsp_valid,
    output logic [ENG_W-1:0]         rsp_eng,
    output logic [TAG_W-1:0]         rsp_tag,
    output logic                     rsp_hit,
    output logic [PORT_W-1:0]        rsp_port
);

    localparam int ELEM_W = ENG_W + TAG_W + 2*IDX_W + KEY_W + LEN_W;
    localparam int ENT_W  = KEY_W + LEN_W + PORT_W + IDX_W;
    localparam int CNT_W  = $clog2(QDEPTH + 1);

    logic [NUM_ENG*ELEM_W-1:0] push_data;
    logic [ELEM_W-1:0]         head_data;
    logic                      q_empty, pop_w, rd_en_w, rd_valid_w;
    logic [CNT_W-1:0]          q_count;
    logic [IDX_W-1:0]          rd_addr_w;
    logic [ENT_W-1:0]          rd_data_w;
    logic [ENG_W-1:0]          hd_eng;
    logic [TAG_W-1:0]          hd_tag;
    logic [IDX_W-1:0]          hd_idx1, hd_idx2;
    logic [KEY_W-1:0]          hd_key;
    logic [LEN_W-1:0]          hd_len;

    // Pack each engine's request with its engine number.
    for (genvar g = 0; g < NUM_ENG; g++) begin : g_pack
        assign push_data[g*ELEM_W +: ELEM_W] = {ENG_W'(g),
                                                req_tag[g*TAG_W +: TAG_W],
                                                req_idx1[g*IDX_W +: IDX_W],
                                                req_idx2[g*IDX_W +: IDX_W],
                                                req_key[g*KEY_W +: KEY_W],
                                                req_len[g*LEN_W +: LEN_W]};
    end

    assign {hd_eng, hd_tag, hd_idx1, hd_idx2, hd_key, hd_len} = head_data;

    rsl_req_queue #(
        .NUM_ENG(NUM_ENG), .QDEPTH(QDEPTH), .ELEM_W(ELEM_W), .CNT_W(CNT_W)
    ) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push_valid(req_valid), .push_data(push_data), .push_ready(req_ready),
        .pop(pop_w), .head_data(head_data), .empty(q_empty), .count(q_count)
    );

    rsl_table #(
        .DEPTH(TBL_DEPTH), .IDX_W(IDX_W), .ENT_W(ENT_W), .RD_LAT(RD_LAT)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_we), .wr_addr(tbl_waddr),
        .wr_data({tbl_wprefix, tbl_wlen, tbl_wport, tbl_wnext}),
        .rd_en(rd_en_w), .rd_addr(rd_addr_w),
        .rd_valid(rd_valid_w), .rd_data(rd_data_w)
    );

    rsl_prober #(
        .KEY_W(KEY_W), .LEN_W(LEN_W), .PORT_W(PORT_W), .IDX_W(IDX_W),
        .TAG_W(TAG_W), .ENG_W(ENG_W), .ENT_W(ENT_W)
    ) u_prober (
        .clk(clk), .rst_n(rst_n),
        .head_valid(!q_empty), .hd_eng(hd_eng), .hd_tag(hd_tag),
        .hd_idx1(hd_idx1), .hd_idx2(hd_idx2), .hd_key(hd_key), .hd_len(hd_len),
        .pop(pop_w), .rd_en(rd_en_w), .rd_addr(rd_addr_w),
        .rd_valid(rd_valid_w), .rd_data(rd_data_w),
        .rsp_valid(rsp_valid), .rsp_eng(rsp_eng), .rsp_tag(rsp_tag),
        .rsp_hit(rsp_hit), .rsp_port(rsp_port)
    );

endmodule

// File: rtl/rsl_checker.sv
// Temporal properties of the resolver, bound to every hash_resolver instance.
module rsl_checker #(
    parameter int NUM_ENG = 2,
    parameter int QDEPTH  = 4,
    parameter int CNT_W   = 3,
    parameter int PORT_W  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_ENG-1:0] req_ready,
    input logic [CNT_W-1:0]   q_count,
    input logic               pop,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [PORT_W-1:0]  rsp_port
);

    // R11: ready is a low-aligned run of ones
    p_ready_thermo_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & (req_ready + {{(NUM_ENG-1){1'b0}}, 1'b1})) == '0);

    // R11: a full queue accepts from nobody
    p_full_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == CNT_W'(QDEPTH)) |-> (req_ready == '0));

    // R11: fill count never exceeds the depth
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(QDEPTH));

    // R9: only a queued request can complete
    p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (q_count != '0));

    // R6: a miss reports port zero
    p_miss_port_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_port == '0));

    // R12: a response lasts one cycle
    p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

bind hash_resolver rsl_checker #(
    .NUM_ENG(NUM_ENG), .QDEPTH(QDEPTH), .CNT_W(CNT_W), .PORT_W(PORT_W)
) u_rsl_checker (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .q_count(q_count),
    .pop(pop_w), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_port(rsp_port)
);

// File: tb/tb_hash_resolver.sv
// Bench: loads a 16-entry table from a formula, sweeps every index pair
// against an arithmetic reference, then exercises ordering and backpressure.
module tb_hash_resolver;

    localparam int NE = 2, TW = 4, KW = 32, LW = 6, PW = 3, DEP = 16, IW = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NE-1:0]  req_valid = '0;
    logic [NE-1:0]  req_ready;
    logic [NE*TW-1:0] req_tag = '0;
    logic [NE*IW-1:0] req_idx1 = '0, req_idx2 = '0;
    logic [NE*KW-1:0] req_key = '0;
    logic [NE*LW-1:0] req_len = '0;
    logic           tbl_we = 1'b0;
    logic [IW-1:0]  tbl_waddr = '0, tbl_wnext = '0;
    logic [KW-1:0]  tbl_wprefix = '0;
    logic [LW-1:0]  tbl_wlen = '0;
    logic [PW-1:0]  tbl_wport = '0;
    logic           rsp_valid, rsp_hit;
    logic [0:0]     rsp_eng;
    logic [TW-1:0]  rsp_tag;
    logic [PW-1:0]  rsp_port;

    int n_chk = 0, n_bad = 0, rcv_n = 0;
    bit done = 0;
    logic [31:0] t_pre [DEP];
    logic [5:0]  t_len [DEP];
    logic [2:0]  t_port [DEP];
    logic [3:0]  t_next [DEP];
    logic        r_eng [1024];
    logic [3:0]  r_tag [1024];
    logic        r_hit [1024];
    logic [2:0]  r_port [1024];

    always #5 clk = ~clk;

    hash_resolver dut (
        .clk, .rst_n, .req_valid, .req_ready, .req_tag, .req_idx1, .req_idx2,
        .req_key, .req_len, .tbl_we, .tbl_waddr, .tbl_wprefix, .tbl_wlen,
        .tbl_wport, .tbl_wnext, .rsp_valid, .rsp_eng, .rsp_tag, .rsp_hit,
        .rsp_port
    );

    // Log every response away from the active edge.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            r_eng[rcv_n]  = rsp_eng[0];
            r_tag[rcv_n]  = rsp_tag;
            r_hit[rcv_n]  = rsp_hit;
            r_port[rcv_n] = rsp_port;
            rcv_n = rcv_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit ent_match(input int e, input logic [31:0] key, input logic [5:0] len);
        logic [31:0] m;
        m = ~(32'hFFFF_FFFF >> len);
        return (t_len[e] != 6'h3F) && (t_len[e] == len) && (((t_pre[e] ^ key) & m) == 0);
    endfunction

    // Reference: which slot answers (1,2,3) or 0 on a miss.
    function automatic int ref_slot(input int i1, input int i2, input logic [31:0] key,
                                    input logic [5:0] len, output int ent);
        ent = 0;
        if (ent_match(i1, key, len)) begin ent = i1; return 1; end
        if (ent_match(i2, key, len)) begin ent = i2; return 2; end
        if (t_next[i2] != 4'hF && ent_match(int'(t_next[i2]), key, len)) begin
            ent = int'(t_next[i2]); return 3;
        end
        return 0;
    endfunction

    task automatic wr_ent(input int i, input logic [31:0] p, input logic [5:0] l,
                          input logic [2:0] pt, input logic [3:0] nx);
        t_pre[i] = p; t_len[i] = l; t_port[i] = pt; t_next[i] = nx;
        @(negedge clk);
        tbl_we = 1'b1; tbl_waddr = 4'(i); tbl_wprefix = p; tbl_wlen = l;
        tbl_wport = pt; tbl_wnext = nx;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic drive(input int e, input int tag, input int i1, input int i2,
                         input logic [31:0] key, input logic [5:0] len);
        req_valid[e] = 1'b1;
        req_tag[e*TW +: TW]  = 4'(tag);
        req_idx1[e*IW +: IW] = 4'(i1);
        req_idx2[e*IW +: IW] = 4'(i2);
        req_key[e*KW +: KW]  = key;
        req_len[e*LW +: LW]  = len;
    endtask

    task automatic wait_rsp(input int target);
        for (int k = 0; k < 200 && rcv_n < target; k++) @(negedge clk);
    endtask

    // One request through engine e, compared with the reference.
    task automatic lookup(input int e, input int tag, input int i1, input int i2,
                          input logic [31:0] key, input logic [5:0] len, input string lbl);
        int slot, ent, base;
        string req;
        slot = ref_slot(i1, i2, key, len, ent);
        req = lbl;
        if (req == "") req = (slot == 1) ? "R2" : (slot == 2) ? "R3" : (slot == 3) ? "R4" : "R6";
        base = rcv_n;
        @(negedge clk);
        drive(e, tag, i1, i2, key, len);
        while (!req_ready[e]) @(negedge clk);
        @(negedge clk);
        req_valid[e] = 1'b0;
        wait_rsp(base + 1);
        chk(rcv_n == base + 1, {req, " one response"}, rcv_n - base, 1);
        if (rcv_n == base + 1) begin
            chk(r_hit[base] == (slot != 0), {req, " hit"}, r_hit[base], slot != 0);
            chk(r_port[base] == ((slot != 0) ? t_port[ent] : 3'd0), {req, " port"},
                r_port[base], (slot != 0) ? t_port[ent] : 0);
            chk(r_tag[base] == 4'(tag), "R9 tag", r_tag[base], tag);
            chk(r_eng[base] == 1'(e), "R9 engine", r_eng[base], e);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int base;
        logic [31:0] miss_key;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        chk(req_ready == 2'b11, "R1 ready", req_ready, 3);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);

        // Table: distinct prefixes, lengths 8..23, entry 5 empty,
        // pointers of all ones on entries 3,7,11,15.
        for (int i = 0; i < DEP; i++) begin
            wr_ent(i, {4'(i), 4'hA, 8'(i * 17), 16'h0},
                   (i == 5) ? 6'h3F : 6'(8 + i), 3'(i % 8),
                   (i % 4 == 3) ? 4'hF : 4'((i * 5 + 2) % 16));
        end

        // Sweep of every index pair with a key aimed at a formula-chosen entry.
        for (int i1 = 0; i1 < DEP; i1++) begin
            for (int i2 = 0; i2 < DEP; i2++) begin
                int t;
                logic [31:0] key;
                logic [5:0] len;
                t = (i1 * 3 + i2) % DEP;
                len = (t == 5) ? 6'd13 : t_len[t];
                key = t_pre[t] ^ 32'h0000_00FF;
                if (i2 % 2 == 1 && t % 3 == 0) key = key ^ (32'h1 << (32 - len));
                lookup(i1 % 2, i2, i1, i2, key, len, "");
            end
        end

        // R8: masked low bits ignored, wrong length and empty entry never match
        lookup(0, 1, 4, 0, t_pre[4] ^ 32'h000F_FFFF, 6'd12, "R8 mask");
        lookup(0, 2, 4, 0, t_pre[4], 6'd11, "R8 length");
        lookup(1, 3, 5, 0, t_pre[5], 6'd13, "R8 empty");
        lookup(1, 4, 5, 0, t_pre[5], 6'h3F, "R8 empty code");
        // R7: pointer all ones, entry 15 would match but is never read
        lookup(0, 5, 0, 3, t_pre[15], t_len[15], "R7");
        // R4: chained hit (entry 1 points at entry 7)
        lookup(0, 6, 0, 1, t_pre[7], t_len[7], "R4");
        // R5: same key in both indexed slots; first index wins
        wr_ent(9, t_pre[4], t_len[4], 3'd1, t_next[9]);
        lookup(0, 7, 4, 9, t_pre[4], t_len[4], "R5 first=4");
        lookup(1, 8, 9, 4, t_pre[4], t_len[4], "R5 first=9");
        chk(t_port[9] != t_port[4], "R5 setup", t_port[9], t_port[4]);

        // R10/R11/R9: two simultaneous pairs of pushes of three-probe misses
        miss_key = 32'hFFFF_FFF0;
        base = rcv_n;
        @(negedge clk);
        drive(0, 10, 0, 1, miss_key, 6'd30);
        drive(1, 11, 0, 1, miss_key, 6'd30);
        @(negedge clk);
        drive(0, 12, 2, 6, miss_key, 6'd30);
        drive(1, 13, 2, 6, miss_key, 6'd30);
        @(negedge clk);
        req_valid = '0;
        chk(req_ready == 2'b00, "R11 full", req_ready, 0);
        for (int k = 0; k < 100 && !rsp_valid; k++) @(negedge clk);
        chk(req_ready == 2'b01, "R11 one free", req_ready, 1);
        wait_rsp(base + 4);
        chk(rcv_n == base + 4, "R12 count", rcv_n - base, 4);
        for (int k = 0; k < 4; k++) begin
            chk(r_tag[base + k] == 4'(10 + k), "R10 order tag", r_tag[base + k], 10 + k);
            chk(r_eng[base + k] == 1'(k % 2), "R10 order engine", r_eng[base + k], k % 2);
            chk(r_hit[base + k] == 1'b0, "R6 miss", r_hit[base + k], 0);
        end
        repeat (20) @(negedge clk);
        chk(rcv_n == base + 4, "R12 no extra response", rcv_n - base, 4);
        chk(req_ready == 2'b11, "R11 drained", req_ready, 3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule